// File: doc/BRIEF.md
# Integer Compare and Byte-Find Unit

This unit is the integer helper stage of a small RISC core's execute path. It takes two operands, an operation code and a carry-in, and produces one result word. It supports five operations: signed compare, unsigned compare, byte-find, count-leading-zeros, and the carry out of an add with carry.

The compare operations do not return separate flags. They return the difference `b - a`, with the most significant bit corrected so that software can test that single bit as the ordering flag. Byte-find scans the two operands byte by byte and reports where they first agree. The core's decode logic drives the operation code. The register file supplies the operands and stores the result.

A parameter selects whether the result leaves through an output register, which adds one cycle of latency, or comes straight from the combinational logic.

Top module: `int_cmp_find_unit`

## Requirements
- R1: Operation code 0 (signed compare) yields `b - a` in two's complement. When bit 31 of `a` and bit 31 of `b` differ, bit 31 of the result is replaced by bit 31 of `b`.
- R2: Operation code 1 (unsigned compare) yields `b - a` in two's complement. When bit 31 of the two operands differ, bit 31 of the result is replaced by bit 31 of `a`.
- R3: Operation code 2 (byte-find) compares the operands byte by byte, beginning at bits 31:24. It returns the 1-based index of the first equal byte: 1 for bits 31:24, 2 for bits 23:16, 3 for bits 15:8 and 4 for bits 7:0.
- R4: Byte-find returns 0 when no byte position of `a` equals the same byte position of `b`.
- R5: Operation code 3 returns the number of leading zero bits of `a`. An all-zero `a` gives 32.
- R6: Operation code 4 returns, in bit 0, the carry out of the 32-bit sum `a + b + carry_in`. All higher bits of the result are 0.
- R7: Operation codes 5, 6 and 7 produce a zero result.
- R8: With the output register enabled (the default), the result appears one clock after its inputs, and reset forces the result to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low reset of the output register |
| op_sel | input | 3 | Operation code |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| carry_in | input | 1 | Carry-in for the carry operation |
| result | output | 32 | Operation result |

## Verification
The assertions check the following on every cycle:
- the compare results match the low 31 bits of the difference;
- identical operands give a zero signed compare and a byte-find of 1;
- byte-find never goes above four;
- count-leading-zeros gives the two extreme values (0 and 32);
- the carry result occupies only bit 0;
- unused codes return zero.

The remaining behaviour can only be shown by the bench scenarios, run under random and directed operands:
- the exact corrected sign bit when the operand signs differ;
- byte-find priority when several bytes match at once;
- exact leading-zero counts;
- the carry at the all-ones boundary with carry-in set;
- reset clearing the registered result.

// File: rtl/int_cmp_find_unit.sv
module int_cmp_find_unit #(
  parameter int WIDTH   = 32,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       op_sel,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] result
);
  localparam int NBYTES = WIDTH / 8;
  localparam int CNT_W  = $clog2(WIDTH + 1);
  localparam int IDX_W  = $clog2(NBYTES + 1);

  localparam logic [2:0] OP_SCMP  = 3'd0;
  localparam logic [2:0] OP_UCMP  = 3'd1;
  localparam logic [2:0] OP_FIND  = 3'd2;
  localparam logic [2:0] OP_CLZ   = 3'd3;
  localparam logic [2:0] OP_CARRY = 3'd4;

  logic [WIDTH-1:0] diff, scmp_val, ucmp_val, res_next;
  logic             sign_mix, carry_out, lz_done;
  logic [IDX_W-1:0] find_idx;
  logic [CNT_W-1:0] lz_cnt;

  assign diff     = opnd_b - opnd_a;
  assign sign_mix = opnd_a[WIDTH-1] ^ opnd_b[WIDTH-1];
  assign scmp_val = {sign_mix ? opnd_b[WIDTH-1] : diff[WIDTH-1], diff[WIDTH-2:0]};
  assign ucmp_val = {sign_mix ? opnd_a[WIDTH-1] : diff[WIDTH-1], diff[WIDTH-2:0]};

  // carry out of a+b+cin is set exactly when ~a < b+cin
  assign carry_out = {1'b0, ~opnd_a} < ({1'b0, opnd_b} + {{WIDTH{1'b0}}, carry_in});

  always_comb begin
    find_idx = '0;
    for (int k = NBYTES - 1; k >= 0; k--) begin
      if (find_idx == '0 && opnd_a[k*8 +: 8] == opnd_b[k*8 +: 8])
        find_idx = IDX_W'(NBYTES - k);
    end
  end

  always_comb begin
    lz_cnt  = CNT_W'(WIDTH);
    lz_done = 1'b0;
    for (int k = WIDTH - 1; k >= 0; k--) begin
      if (!lz_done && opnd_a[k]) begin
        lz_cnt  = CNT_W'(WIDTH - 1 - k);
        lz_done = 1'b1;
      end
    end
  end

  always_comb begin
    case (op_sel)
      OP_SCMP:  res_next = scmp_val;
      OP_UCMP:  res_next = ucmp_val;
      OP_FIND:  res_next = {{(WIDTH-IDX_W){1'b0}}, find_idx};
      OP_CLZ:   res_next = {{(WIDTH-CNT_W){1'b0}}, lz_cnt};
      OP_CARRY: res_next = {{(WIDTH-1){1'b0}}, carry_out};
      default:  res_next = '0;
    endcase
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) result <= '0;
        else        result <= res_next;
      end

      AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel > OP_CARRY) |=> (result == '0)); // R7
      AST_CMP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_SCMP || op_sel == OP_UCMP) |=>
        (result[WIDTH-2:0] == $past(opnd_b[WIDTH-2:0] - opnd_a[WIDTH-2:0]))); // R1
      AST_SCMP_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_SCMP && opnd_a == opnd_b) |=> (result == '0)); // R1
      AST_FIND_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_FIND) |=> (result <= WIDTH'(NBYTES))); // R3
      AST_FIND_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_FIND && opnd_a == opnd_b) |=> (result == WIDTH'(1))); // R3
      AST_CLZ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_CLZ && opnd_a == '0) |=> (result == WIDTH'(WIDTH))); // R5
      AST_CLZ_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_CLZ && opnd_a[WIDTH-1]) |=> (result == '0)); // R5
      AST_CARRY_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_CARRY) |=> (result[WIDTH-1:1] == '0)); // R6
    end else begin : g_comb
      assign result = res_next;
    end
  endgenerate
endmodule

// File: tb/test_int_cmp_find_unit.sv
module test_int_cmp_find_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op_sel = '0;
  logic [31:0] opnd_a = '0, opnd_b = '0;
  logic        carry_in = 1'b0;
  logic [31:0] result;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  int_cmp_find_unit i_int_cmp_find_unit (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .opnd_a(opnd_a),
    .opnd_b(opnd_b), .carry_in(carry_in), .result(result));

  function automatic logic [31:0] exp_val(logic [2:0] op, logic [31:0] a, logic [31:0] b, logic c);
    logic [31:0] d, bc;
    d = b - a;
    case (op)
      3'd0: begin if (a[31] != b[31]) d[31] = b[31]; return d; end
      3'd1: begin if (a[31] != b[31]) d[31] = a[31]; return d; end
      3'd2: begin
        if (a[31:24] == b[31:24]) return 1;
        if (a[23:16] == b[23:16]) return 2;
        if (a[15:8]  == b[15:8])  return 3;
        if (a[7:0]   == b[7:0])   return 4;
        return 0;
      end
      3'd3: begin
        int n = 0;
        while (n < 32 && a[31-n] == 1'b0) n++;
        return 32'(n);
      end
      3'd4: begin
        if (b == 32'hFFFF_FFFF && c) return 1;
        bc = b + {31'd0, c};
        return ((32'hFFFF_FFFF - a) < bc) ? 1 : 0;
      end
      default: return 0;
    endcase
  endfunction

  function automatic string req_of(logic [2:0] op, logic [31:0] e);
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return (e == 0) ? "R4" : "R3";
      3'd3: return "R5";
      3'd4: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(logic [2:0] op, logic [31:0] a, logic [31:0] b, logic c);
    logic [31:0] e;
    @(negedge clk);
    op_sel = op; opnd_a = a; opnd_b = b; carry_in = c;
    e = exp_val(op, a, b, c);
    @(negedge clk);
    check(req_of(op, e), result, e);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    op_sel = 3'd4; opnd_a = 32'hFFFF_FFFF; opnd_b = 32'd1;
    repeat (3) @(negedge clk);
    check("R8 reset", result, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 latency", result, 32'd1);

    apply(3'd0, 32'd5, 32'd9, 0);
    apply(3'd0, 32'd9, 32'd5, 0);
    apply(3'd0, 32'h8000_0000, 32'h7FFF_FFFF, 0);
    apply(3'd0, 32'h7FFF_FFFF, 32'h8000_0000, 0);
    apply(3'd1, 32'h8000_0000, 32'h7FFF_FFFF, 0);
    apply(3'd1, 32'h0000_0001, 32'hFFFF_FFFF, 0);
    apply(3'd2, 32'h1122_3344, 32'h1122_3344, 0);
    apply(3'd2, 32'h0022_0044, 32'h1122_3344, 0);
    apply(3'd2, 32'h1020_3044, 32'h1122_3344, 0);
    apply(3'd2, 32'h0102_0304, 32'h1020_3040, 0);
    apply(3'd3, 32'd0, 32'd0, 0);
    apply(3'd3, 32'd1, 32'd0, 0);
    apply(3'd3, 32'h8000_0000, 32'd0, 0);
    apply(3'd3, 32'h0001_FFFF, 32'd0, 0);
    apply(3'd4, 32'd0, 32'hFFFF_FFFF, 1);
    apply(3'd4, 32'd0, 32'hFFFF_FFFF, 0);
    apply(3'd4, 32'h8000_0000, 32'h8000_0000, 0);
    apply(3'd4, 32'h7FFF_FFFF, 32'h8000_0000, 1);
    apply(3'd5, 32'hDEAD_BEEF, 32'h1234_5678, 1);
    apply(3'd6, 32'h0, 32'h0, 1);
    apply(3'd7, 32'hFFFF_FFFF, 32'h1, 0);

    for (int i = 0; i < 2000; i++) begin
      logic [31:0] a, b;
      a = $urandom;
      b = $urandom;
      if (i % 3 == 0) begin
        for (int k = 0; k < 4; k++)
          if ($urandom_range(1, 0) == 1) b[k*8 +: 8] = a[k*8 +: 8];
      end
      if (i % 7 == 0) a = a >> $urandom_range(31, 0);
      apply(3'($urandom_range(7, 0)), a, b, 1'($urandom_range(1, 0)));
    end

    @(negedge clk);
    op_sel = 3'd3; opnd_a = 32'd0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R8 reset again", result, 32'd0);
    finish_run();
  end
endmodule